// File: doc/BRIEF.md
# Touch Sample FIFO with Status

This block sits between a touch-panel conversion engine and a host register port. Each completed measurement arrives as an X coordinate, a Y coordinate and a pen-level flag. The block packs them into one 32-bit word and keeps up to four words in arrival order. The host reads a status word that shows the fill level, an empty flag and a sticky overrun flag. It reads the data word to pop the oldest sample.

An interrupt output stays high while the number of stored samples is at or above a programmable threshold. This lets the host collect a burst of samples in one service pass instead of taking one interrupt per sample. To clear the buffer, the host reads the data word until the status reports empty. Draining to empty also clears the overrun flag.

The sample input is a valid-only stream with no back-pressure. The converter runs on its own schedule and cannot stall, so the block takes a write in any cycle that `smp_valid` is high. A write that finds the buffer full is discarded and recorded in the overrun flag. It does not stall the converter. The read port is a plain one-cycle request: `rd_en` with a select bit, and `rd_data` registered and valid in the cycle after the request.

Top module: `touch_sample_fifo`

## Requirements
- R1: A data read returns the oldest stored sample as one word: pen level in bit 31, X in bits 25:16, Y in bits 9:0, all other bits zero. X and Y are 10-bit values from 0 to 1023.
- R2: Samples come out in the order they were written. Up to 4 samples are held.
- R3: A write that finds 4 stored samples, with no data pop in the same cycle, is discarded. It sets the overrun flag, status bit 8.
- R4: The overrun flag stays set through reads that leave the buffer non-empty. It clears on the read that empties the buffer.
- R5: A status read returns the empty flag in bit 7, the overrun flag in bit 8 and the stored-sample count in bits 2:0. All other bits are zero. The value reflects the state before the edge at which the read is taken.
- R6: A data read from an empty buffer returns zero and leaves the count and flags unchanged.
- R7: `irq` is high exactly when the threshold is non-zero and the count is at or above it. A threshold of 0 keeps `irq` low.
- R8: A write and a data pop in the same cycle on a full buffer are both carried out. The count stays at 4 and no overrun is recorded.
- R9: After reset the buffer is empty, overrun is clear, `irq` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_pen | input | 1 | Pen-level flag of the sample |
| smp_x | input | 10 | X coordinate |
| smp_y | input | 10 | Y coordinate |
| irq_thr | input | 3 | Interrupt count threshold (0 disables) |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | 0 = status word, 1 = data word (pops) |
| rd_data | output | 32 | Read result, registered, one cycle after the request |
| irq | output | 1 | Level interrupt: count at or above threshold |

## Verification
The assertions assume that `irq_thr` is a static setting, so the interrupt level depends only on the count. They also assume that `rd_sel` is only meaningful while `rd_en` is high. The stimulus changes the threshold only while no read or write is in flight. It drives every input half a cycle away from the sampling edge. It sweeps each threshold against fill levels from empty through overfull, so that drops, drains and empty reads all occur under the checked conditions.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int COORD_W = 10;
  localparam int WORD_W  = 32;
  localparam int PEN_BIT = 31;
  localparam int X_LSB   = 16;
  localparam int Y_LSB   = 0;
  localparam int ST_EMPTY = 7;
  localparam int ST_OVR   = 8;

  function automatic logic [WORD_W-1:0] pack_sample(input logic pen,
                                                    input logic [COORD_W-1:0] x,
                                                    input logic [COORD_W-1:0] y);
    logic [WORD_W-1:0] w;
    w = '0;
    w[PEN_BIT] = pen;
    w[X_LSB +: COORD_W] = x;
    w[Y_LSB +: COORD_W] = y;
    return w;
  endfunction
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop_req,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              dropped,
  output logic              drained
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic full, push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dropped = push && !push_ok;
  assign drained = pop_ok && !push_ok && (count == CNT_W'(1));
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop_req) |=> (count == FULL_CNT));
  p_empty_pop_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push) |=> empty);
  p_full_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && full) |=> (count == FULL_CNT));
endmodule

// File: rtl/tsf_flags.sv
module tsf_flags #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dropped,
  input  logic             drained,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  output logic             ovr,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (dropped) ovr <= 1'b1;
    else if (drained) ovr <= 1'b0;
  end

  assign irq = (thr != '0) && (count >= thr);

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> ovr);
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> (count == '0));
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> !irq);
endmodule

// File: rtl/touch_sample_fifo.sv
module touch_sample_fifo #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_pen,
  input  logic [9:0]       smp_x,
  input  logic [9:0]       smp_y,
  input  logic [CNT_W-1:0] irq_thr,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  output logic             irq
);
  import tsf_pkg::*;

  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  count;
  logic empty, dropped, drained, ovr, pop_req;
  logic [WORD_W-1:0] status;

  assign pop_req = rd_en && rd_sel;

  tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(smp_valid), .din(pack_sample(smp_pen, smp_x, smp_y)),
    .pop_req(pop_req), .head(head), .count(count), .empty(empty),
    .dropped(dropped), .drained(drained)
  );

  tsf_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .dropped(dropped), .drained(drained),
    .count(count), .thr(irq_thr), .ovr(ovr), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[CNT_W-1:0] = count;
    status[ST_EMPTY]  = empty;
    status[ST_OVR]    = ovr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (!rd_sel)    rd_data <= status;
      else if (empty) rd_data <= '0;
      else            rd_data <= head;
    end
  end

  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && empty) |=> (rd_data == '0));
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[30:26] == '0) && (rd_data[15:10] == '0));
endmodule

// File: tb/touch_sample_fifo_test.sv
module touch_sample_fifo_test;
  logic clk = 0;
  logic rst_n = 0;
  logic smp_valid = 0, smp_pen = 0;
  logic [9:0] smp_x = 0, smp_y = 0;
  logic [2:0] irq_thr = 0;
  logic rd_en = 0, rd_sel = 0;
  logic [31:0] rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  touch_sample_fifo uut (.*);

  function automatic logic [31:0] mk(input int pen, input int x, input int y);
    return (32'(pen) << 31) | (32'(x) << 16) | 32'(y);
  endfunction
  function automatic logic [31:0] st(input int ovr, input int cnt);
    return (32'(ovr) << 8) | (32'(cnt == 0) << 7) | 32'(cnt);
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic push(input int pen, input int x, input int y);
    smp_valid = 1; smp_pen = pen[0]; smp_x = 10'(x); smp_y = 10'(y);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] w);
    rd_en = 1; rd_sel = sel;
    @(negedge clk);
    rd_en = 0;
    w = rd_data;
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] expw [8];
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk(rd_data, 0, "R9 rd_data");
    chk(32'(irq), 0, "R9 irq");
    rd(0, w); chk(w, st(0, 0), "R9 status");

    for (int thr = 0; thr < 6; thr++) begin
      for (int n = 0; n < 7; n++) begin
        int held;
        irq_thr = 3'(thr);
        held = (n > 4) ? 4 : n;
        for (int k = 0; k < n; k++) begin
          int x, y, p;
          x = (k * 293 + n * 71 + thr * 13) % 1024;
          y = 1023 - ((k * 157 + n * 29) % 1024);
          p = (k + n) & 1;
          if (k == 0 && n == 4) begin x = 1023; y = 0; end
          expw[k] = mk(p, x, y);
          push(p, x, y);
        end
        // R7 level interrupt
        chk(32'(irq), 32'((thr != 0) && (held >= thr)), "R7 irq level");
        // R5 and R3 status
        rd(0, w); chk(w, st(n > 4, held), "R5 R3 status after fill");
        for (int k = 0; k < held; k++) begin
          rd(1, w); chk(w, expw[k], "R1 R2 data order");
          if (k < held - 1) begin
            rd(0, w); chk(w, st(n > 4, held - 1 - k), "R4 overrun sticky");
          end
        end
        // R6 empty read
        rd(1, w); chk(w, 0, "R6 empty read zero");
        rd(0, w); chk(w, st(0, 0), "R4 R6 drained status");
        chk(32'(irq), 0, "R7 irq after drain");
      end
    end

    // R8 simultaneous push and pop on full buffer
    irq_thr = 3'd4;
    for (int k = 0; k < 4; k++) begin
      expw[k] = mk(1, 100 + k, 200 + k);
      push(1, 100 + k, 200 + k);
    end
    smp_valid = 1; smp_pen = 0; smp_x = 10'd555; smp_y = 10'd777;
    rd_en = 1; rd_sel = 1;
    @(negedge clk);
    smp_valid = 0; rd_en = 0;
    chk(rd_data, expw[0], "R8 popped oldest");
    chk(32'(irq), 1, "R8 irq still high");
    rd(0, w); chk(w, st(0, 4), "R8 no overrun");
    rd(1, w); chk(w, expw[1], "R8 order 1");
    rd(1, w); chk(w, expw[2], "R8 order 2");
    rd(1, w); chk(w, expw[3], "R8 order 3");
    rd(1, w); chk(w, mk(0, 555, 777), "R8 new tail");
    rd(0, w); chk(w, st(0, 0), "R8 empty");

    // R9 reset mid-operation
    push(1, 5, 6);
    push(0, 7, 8);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk(rd_data, 0, "R9 rd_data after reset");
    rd(0, w); chk(w, st(0, 0), "R9 status after reset");

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule